// File: doc/BRIEF.md
# Banked Memory Address Decoder

This block produces the chip selects and bank numbers for an 8-bit processor with a 16-bit address bus. Every bus address maps to exactly one of five regions: the pair of bank registers at the bottom of memory, a 256-byte I/O page, a banked high-RAM window, a banked ROM window, or plain low RAM. Low RAM is the fallback and is selected only when no other region matches.

Two 8-bit bank registers sit at the two lowest addresses. The first holds the RAM bank number and the second holds the ROM bank number. A register is loaded when the bus clock phase, the write strobe and that register's address all hold at a rising clock edge. The register values drive the extended address bits of the memories directly. When the processor reads either register address, the current value appears on a read-back bus.

The selects depend only on the address. No register lies in their path, so they settle within the address setup window and the rest of the bus cycle is left for the memory access.

Top module: `bank_decoder`

## Requirements
- R1: For every address, exactly one bit of `sel` is 1. The bit positions are: bit 0 bank registers, bit 1 I/O, bit 2 high RAM, bit 3 ROM, bit 4 low RAM.
- R2: `sel` bit 0 is set only for addresses $0000 and $0001.
- R3: `sel` bit 1 is set exactly for addresses $9F00 to $9FFF.
- R4: `sel` bit 2 is set exactly for addresses $A000 to $BFFF.
- R5: `sel` bit 3 is set exactly for addresses $C000 to $FFFF.
- R6: `sel` bit 4 is set exactly for addresses $0002 to $9EFF.
- R7: Suppose `phi2`, `we` and an address match all hold at a rising clock edge. If the address is $0000, `ram_bank` takes `wdata` at that edge. If the address is $0001, `rom_bank` takes `wdata` at that edge.
- R8: A write has no effect on either bank register in three cases: `phi2` is low, `we` is low, or the address is neither $0000 nor $0001.
- R9: A rising edge with `rst_n` low clears both bank registers to 0.
- R10: `rdata` equals `ram_bank` while the address is $0000 and equals `rom_bank` while the address is $0001. At every other address it is 0.
- R11: A bank output changes only on the clock edge after a qualified write to its address. At all other times it holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | Processor address bus |
| wdata | input | 8 | Processor write data |
| we | input | 1 | Write strobe, active high |
| phi2 | input | 1 | Bus clock phase qualifier, active high |
| sel | output | 5 | One-hot region selects |
| ram_bank | output | 8 | Current RAM bank number |
| rom_bank | output | 8 | Current ROM bank number |
| rdata | output | 8 | Bank register read-back data |

## Verification
The bench builds the block with its default parameters: a 16-bit address, 8-bit registers, two bank registers and the I/O page at $9F. With these values the whole address space is only 65,536 entries, so the decode is checked against an independent model at every address, including each region edge, instead of at sampled points. The 8-bit register width lets the write tests use patterns that set every bit and clear every bit. Each gating input of a write is withheld on its own to show that the write is then ignored.

// File: rtl/bankdec_pkg.sv
// Package: shared constants for the banked address decoder.
// Assumes: the select vector is one-hot with the bit positions below.
package bankdec_pkg;
    localparam int SEL_W     = 5;
    localparam int SEL_BANK  = 0;
    localparam int SEL_IO    = 1;
    localparam int SEL_HIRAM = 2;
    localparam int SEL_ROM   = 3;
    localparam int SEL_LOW   = 4;
endpackage

// File: rtl/bankdec_region.sv
// Module: bankdec_region
// Purely combinational region decode of the address bus.
// Assumes: IO_PAGE falls inside $80..$9F, so the I/O page lies in the upper
// half and does not overlap the high-RAM or ROM windows. The bank registers
// occupy the lowest 2**IDX_W addresses.
module bankdec_region
    import bankdec_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          IDX_W   = 1,
    parameter logic [7:0]  IO_PAGE = 8'h9F
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [SEL_W-1:0]  sel
);
    localparam int TOP = ADDR_W - 1;

    logic upper_half;
    logic bank_hit, io_hit, hiram_hit, rom_hit;

    // Split on the top bit, then match each region inside its half.
    always_comb begin
        upper_half = addr[TOP];
        bank_hit   = !upper_half && (addr[TOP-1:IDX_W] == '0);
        io_hit     = upper_half && (addr[TOP -: 8] == IO_PAGE);
        hiram_hit  = upper_half && (addr[TOP-1 -: 2] == 2'b01);
        rom_hit    = upper_half && addr[TOP-1];
    end

    // Assemble the one-hot vector; low RAM is whatever is left over.
    always_comb begin
        sel            = '0;
        sel[SEL_BANK]  = bank_hit;
        sel[SEL_IO]    = io_hit;
        sel[SEL_HIRAM] = hiram_hit;
        sel[SEL_ROM]   = rom_hit;
        sel[SEL_LOW]   = !(bank_hit || io_hit || hiram_hit || rom_hit);
    end
endmodule

// File: rtl/bankdec_regs.sv
// Module: bankdec_regs
// The bank register file. Register i loads on a qualified write to index i.
// Assumes: bank_sel comes from the region decode and idx from the low
// address bits. The reset is synchronous and active low.
module bankdec_regs #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 2,
    parameter int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             bank_sel,
    input  logic [IDX_W-1:0]                 idx,
    input  logic                             we,
    input  logic                             phi2,
    input  logic [DATA_W-1:0]                wdata,
    output logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q,
    output logic [DATA_W-1:0]                rdata
);
    logic wr_ok;

    // A write counts only when phase, strobe and select coincide.
    always_comb wr_ok = phi2 && we && bank_sel;

    for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
        // Hold or load register i on each clock edge.
        always_ff @(posedge clk) begin
            if (!rst_n)
                bank_q[i] <= '0;
            else if (wr_ok && (idx == IDX_W'(i)))
                bank_q[i] <= wdata;
        end
    end

    // Read-back multiplexer; it returns zero outside the register window.
    always_comb rdata = bank_sel ? bank_q[idx] : '0;
endmodule

// File: rtl/bank_decoder.sv
// Module: bank_decoder (top)
// Chip-select and bank-register logic for a 16-bit address bus.
// Assumes: selects are combinational from addr. Bank outputs update only at
// a clock edge on which phi2 and we are high and addr hits a register.
module bank_decoder
    import bankdec_pkg::*;
#(
    parameter int          ADDR_W  = 16,
    parameter int          DATA_W  = 8,
    parameter logic [7:0]  IO_PAGE = 8'h9F
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [15:0]       addr,
    input  logic [7:0]        wdata,
    input  logic              we,
    input  logic              phi2,
    output logic [4:0]        sel,
    output logic [7:0]        ram_bank,
    output logic [7:0]        rom_bank,
    output logic [7:0]        rdata
);
    localparam int NUM_REGS = 2;
    localparam int IDX_W    = $clog2(NUM_REGS);
    localparam int RAM_IDX  = 0;
    localparam int ROM_IDX  = 1;

    logic [SEL_W-1:0]                 sel_w;
    logic [NUM_REGS-1:0][DATA_W-1:0]  bank_q;

    bankdec_region #(
        .ADDR_W  (ADDR_W),
        .IDX_W   (IDX_W),
        .IO_PAGE (IO_PAGE)
    ) u_region (
        .addr (addr),
        .sel  (sel_w)
    );

    bankdec_regs #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .IDX_W    (IDX_W)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .bank_sel (sel_w[SEL_BANK]),
        .idx      (addr[IDX_W-1:0]),
        .we       (we),
        .phi2     (phi2),
        .wdata    (wdata),
        .bank_q   (bank_q),
        .rdata    (rdata)
    );

    // Drive the selects and the extended bank bits out of the block.
    always_comb begin
        sel      = sel_w;
        ram_bank = bank_q[RAM_IDX];
        rom_bank = bank_q[ROM_IDX];
    end
endmodule

// File: rtl/bankdec_checker.sv
// Module: bankdec_checker
// Temporal and structural properties of bank_decoder, attached with bind.
module bankdec_checker (
    input logic        clk,
    input logic        rst_n,
    input logic [15:0] addr,
    input logic [7:0]  wdata,
    input logic        we,
    input logic        phi2,
    input logic [4:0]  sel,
    input logic [7:0]  ram_bank,
    input logic [7:0]  rom_bank,
    input logic [7:0]  rdata
);
    // R1: exactly one select is active.
    p_one_select_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(sel) == 1);

    // R2: the register select appears only in the lowest two addresses.
    p_bank_window_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sel[0] |-> (addr[15:1] == 15'd0));

    // R3: the I/O select implies the I/O page.
    p_io_page_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sel[1] |-> (addr[15:8] == 8'h9F));

    // R5: the ROM select implies the top quarter of memory.
    p_rom_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sel[3] |-> (addr[15:14] == 2'b11));

    // R7: a qualified write to $0000 lands in the RAM bank.
    p_ram_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && we && addr == 16'h0000) |=> (ram_bank == $past(wdata)));

    // R7: a qualified write to $0001 lands in the ROM bank.
    p_rom_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (phi2 && we && addr == 16'h0001) |=> (rom_bank == $past(wdata)));

    // R11: without a qualified register write, both banks hold.
    p_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(phi2 && we && addr[15:1] == 15'd0) |=> ($stable(ram_bank) && $stable(rom_bank)));

    // R10: outside the register window the read-back is zero.
    p_rdata_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (addr[15:1] != 15'd0) |-> (rdata == 8'd0));
endmodule

bind bank_decoder bankdec_checker u_bankdec_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wdata    (wdata),
    .we       (we),
    .phi2     (phi2),
    .sel      (sel),
    .ram_bank (ram_bank),
    .rom_bank (rom_bank),
    .rdata    (rdata)
);

// File: tb/bank_decoder_bench.sv
// Directed bench for bank_decoder: one task per scenario, each self-checking.
module bank_decoder_bench;
    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr  = 16'h0000;
    logic [7:0]  wdata = 8'h00;
    logic        we    = 1'b0;
    logic        phi2  = 1'b0;
    logic [4:0]  sel;
    logic [7:0]  ram_bank, rom_bank, rdata;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    bank_decoder u_bank_decoder (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .we(we),
        .phi2(phi2), .sel(sel), .ram_bank(ram_bank), .rom_bank(rom_bank),
        .rdata(rdata)
    );

    always #2 clk = ~clk;

    // Independent model of the region map stated in R2..R6.
    function automatic logic [4:0] model_sel(input int a);
        if (a <= 1)               return 5'b00001;
        if (a >= 'h9F00 && a <= 'h9FFF) return 5'b00010;
        if (a >= 'hA000 && a <= 'hBFFF) return 5'b00100;
        if (a >= 'hC000)          return 5'b01000;
        return 5'b10000;
    endfunction

    task automatic check8(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one bus cycle at a falling edge; the write lands at the next rising edge.
    task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                             input logic w, input logic ph);
        @(negedge clk);
        addr = a; wdata = d; we = w; phi2 = ph;
        @(negedge clk);
        we = 1'b0; phi2 = 1'b0; addr = 16'h4000;
    endtask

    task automatic t_reset;
        check8("R9 ram_bank after reset", ram_bank, 8'h00);
        check8("R9 rom_bank after reset", rom_bank, 8'h00);
    endtask

    task automatic t_map_sweep;
        int bad = 0;
        for (int a = 0; a < 65536; a++) begin
            addr = a[15:0];
            #1;
            checks++;
            if (sel !== model_sel(a)) begin
                errors++;
                bad++;
                if (bad < 8)
                    $display("FAIL R1-map addr=%h actual=%b expected=%b (R2 R3 R4 R5 R6)",
                             a[15:0], sel, model_sel(a));
            end
        end
        addr = 16'h4000;
    endtask

    task automatic t_writes;
        bus_write(16'h0000, 8'hFF, 1'b1, 1'b1);
        check8("R7 ram_bank load FF", ram_bank, 8'hFF);
        check8("R7 rom_bank untouched", rom_bank, 8'h00);
        bus_write(16'h0001, 8'hA5, 1'b1, 1'b1);
        check8("R7 rom_bank load A5", rom_bank, 8'hA5);
        check8("R11 ram_bank held", ram_bank, 8'hFF);
        bus_write(16'h0000, 8'h00, 1'b1, 1'b1);
        check8("R7 ram_bank load 00", ram_bank, 8'h00);
        bus_write(16'h0000, 8'h3C, 1'b1, 1'b1);
        check8("R7 ram_bank load 3C", ram_bank, 8'h3C);
    endtask

    task automatic t_ignored;
        bus_write(16'h0000, 8'h11, 1'b1, 1'b0);
        check8("R8 no phi2 ram_bank", ram_bank, 8'h3C);
        bus_write(16'h0001, 8'h22, 1'b0, 1'b1);
        check8("R8 no we rom_bank", rom_bank, 8'hA5);
        bus_write(16'h0002, 8'h33, 1'b1, 1'b1);
        check8("R8 addr 0002 ram_bank", ram_bank, 8'h3C);
        check8("R8 addr 0002 rom_bank", rom_bank, 8'hA5);
        bus_write(16'h8000, 8'h44, 1'b1, 1'b1);
        check8("R8 addr 8000 ram_bank", ram_bank, 8'h3C);
        bus_write(16'h8001, 8'h55, 1'b1, 1'b1);
        check8("R8 addr 8001 rom_bank", rom_bank, 8'hA5);
        bus_write(16'h0100, 8'h66, 1'b1, 1'b1);
        check8("R11 addr 0100 ram_bank", ram_bank, 8'h3C);
    endtask

    task automatic t_readback;
        @(negedge clk); addr = 16'h0000; #1;
        check8("R10 read 0000", rdata, 8'h3C);
        addr = 16'h0001; #1;
        check8("R10 read 0001", rdata, 8'hA5);
        addr = 16'h9F00; #1;
        check8("R10 read 9F00 zero", rdata, 8'h00);
        addr = 16'h8001; #1;
        check8("R10 read 8001 zero", rdata, 8'h00);
    endtask

    task automatic t_reset_again;
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check8("R9 ram_bank cleared", ram_bank, 8'h00);
        check8("R9 rom_bank cleared", rom_bank, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset;
        t_map_sweep;
        check8("R11 banks stable over sweep", ram_bank | rom_bank, 8'h00);
        t_writes;
        t_ignored;
        t_readback;
        t_reset_again;
        done = 1'b1;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        for (int c = 0; c < 150000 && !done; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule